// File: doc/BRIEF.md
# External Clock Enable and Startup Timer

This block holds the control and status state for an off-chip clock generator. An enable bit turns the generator on. Software may write that bit. Hardware forces it high while the clock monitor or the clock-select input is active. Software may clear it only after both inputs have been quiet for a full bus cycle.

Once the generator is enabled, a counter clocked by the external clock counts a fixed startup period. A ready flag then rises in the bus domain. The flag is a startup delay only and does not prove that the clock is good. It is forced low whenever any of these hold:
- the monitor reports the external clock as dead;
- the enable bit is low;
- the part is in stop mode without its oscillator kept running;
- reset is asserted.

The block also holds a 7-bit multiplier for a downstream synthesizer. A stored zero is delivered as one. Writes to the multiplier are refused while monitoring is active.

Software reaches the block through a plain two-register port. Address 0 is the control register: bit 7 is the enable bit, bit 6 is the ready flag, and the other bits read as 0. Address 1 is the multiplier register: bits 6:0 hold the multiplier and bit 7 reads as 0. Writes take effect on the bus clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. There is no data stream, so there is no handshake.

Top module: `xclk_ctl`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the multiplier register (address 1) reads 0x15, and `gen_stable` is 0.
- R2: While `mon_en` or `sel_ext` is 1, `gen_en` is 1 from the next bus edge on, and a software write of 0 to control bit 7 has no effect.
- R3: A write of 0 to control bit 7 clears `gen_en` only if `mon_en` and `sel_ext` were both 0 at the write edge and at the bus edge before it.
- R4: A write of 1 to control bit 7 sets `gen_en`.
- R5: `gen_stable` (control bit 6) rises only after at least 4096 `xclk` rising edges have occurred with the enable bit set and no clear condition present. It then stays high while no clear condition holds.
- R6: `gen_stable` goes low at once, and the count restarts, whenever any of these holds: `xclk_dead` is 1, `gen_en` is 0, or `stop_mode` is 1 while `osc_in_stop` is 0. Stop mode with `osc_in_stop` high leaves the flag high.
- R7: A write to address 1 stores `reg_wdata[6:0]`. Bit 7 of the multiplier register always reads as 0.
- R8: `mult_eff` equals the stored multiplier, except that a stored 0 gives 1.
- R9: While `mon_en` is 1, writes to address 1 leave the multiplier unchanged.
- R10: Control bits 5:0 read as 0, and writing control bit 6 does not change the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xclk | input | 1 | External clock being started |
| reg_addr | input | 1 | Register select: 0 control, 1 multiplier |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| mon_en | input | 1 | Clock monitor active |
| sel_ext | input | 1 | External clock selected as source |
| xclk_dead | input | 1 | Monitor reports the external clock inactive |
| stop_mode | input | 1 | Device in stop mode |
| osc_in_stop | input | 1 | Strap: keep the oscillator running in stop |
| gen_en | output | 1 | Generator enable |
| gen_stable | output | 1 | Startup period elapsed |
| mult_eff | output | 7 | Effective multiplier, never zero |

## Verification
The bench writes 0 to the enable bit in the same cycle that clock select drops. A design that ignored the one-cycle quiet window would clear the bit there, when it should keep it. The bench samples the ready flag well short of the 4096-edge count and again past it. It also removes each clear condition in turn, which catches an off-by-large count, a flag that never restarts, and a flag left high after its clock dies. The bench stores zero into the multiplier and attempts writes while the monitor is active. A design that passed zero through, or ignored the lock, shows a wrong effective value or a changed read.

// File: rtl/xclk_pkg.sv
package xclk_pkg;
  localparam logic       ADDR_CTRL  = 1'b0;
  localparam logic       ADDR_MULT  = 1'b1;
  localparam int         EN_BIT     = 7;
  localparam int         STABLE_BIT = 6;
  localparam int         MULT_W     = 7;
  localparam logic [6:0] MULT_RST   = 7'h15;
endpackage

// File: rtl/xclk_enable_ctl.sv
module xclk_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic force_on,
  input  logic wr_ctrl,
  input  logic wr_val,
  output logic en
);
  logic quiet_q;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      quiet_q <= ~force_on;
      if (force_on)
        en_q <= 1'b1;
      else if (wr_ctrl && wr_val)
        en_q <= 1'b1;
      else if (wr_ctrl && !wr_val && quiet_q)
        en_q <= 1'b0;
    end
  end

  assign en = en_q;

  assert_force_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |=> en_q);
  assert_clear_needs_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> (!$past(force_on, 1) && !$past(force_on, 2)));
endmodule

// File: rtl/xclk_startup_cnt.sv
module xclk_startup_cnt #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic xclk,
  input  logic clr,
  output logic stable
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;
  logic          done;
  logic          s1, s2;

  always_ff @(posedge xclk or posedge clr) begin
    if (clr)
      cnt <= '0;
    else if (cnt != LIM)
      cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= done;
      s2 <= s1;
    end
  end

  assign stable = s2 & ~clr;

  assert_cnt_saturates_R5: assert property (@(posedge xclk) disable iff (clr)
    cnt <= LIM);
endmodule

// File: rtl/xclk_mult_reg.sv
module xclk_mult_reg
  import xclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              lock,
  input  logic [MULT_W-1:0] wdata,
  output logic [MULT_W-1:0] stored,
  output logic [MULT_W-1:0] eff
);
  logic [MULT_W-1:0] mult_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mult_q <= MULT_RST;
    else if (wr && !lock)
      mult_q <= wdata;
  end

  assign stored = mult_q;
  assign eff    = (mult_q == '0) ? MULT_W'(1) : mult_q;

  assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(mult_q));
  assert_eff_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eff != '0);
endmodule

// File: rtl/xclk_ctl.sv
module xclk_ctl
  import xclk_pkg::*;
#(
  parameter int START_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xclk,
  input  logic       reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       mon_en,
  input  logic       sel_ext,
  input  logic       xclk_dead,
  input  logic       stop_mode,
  input  logic       osc_in_stop,
  output logic       gen_en,
  output logic       gen_stable,
  output logic [6:0] mult_eff
);
  logic              wr_ctrl, wr_mult, clr_cnt;
  logic [MULT_W-1:0] mult_stored;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_mult = reg_wr && (reg_addr == ADDR_MULT);

  xclk_enable_ctl u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_on (mon_en | sel_ext),
    .wr_ctrl  (wr_ctrl),
    .wr_val   (reg_wdata[EN_BIT]),
    .en       (gen_en)
  );

  assign clr_cnt = ~rst_n | xclk_dead | ~gen_en | (stop_mode & ~osc_in_stop);

  xclk_startup_cnt #(.LIMIT(START_CYCLES)) u_cnt (
    .clk    (clk),
    .xclk   (xclk),
    .clr    (clr_cnt),
    .stable (gen_stable)
  );

  xclk_mult_reg u_mult (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_mult),
    .lock   (mon_en),
    .wdata  (reg_wdata[MULT_W-1:0]),
    .stored (mult_stored),
    .eff    (mult_eff)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL) begin
      reg_rdata[EN_BIT]     = gen_en;
      reg_rdata[STABLE_BIT] = gen_stable;
    end else begin
      reg_rdata[MULT_W-1:0] = mult_stored;
    end
  end
endmodule

// File: tb/xclk_ctl_tb.sv
module xclk_ctl_tb;
  logic       clk = 0, xclk = 0, rst_n = 0;
  logic       reg_addr = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       mon_en = 0, sel_ext = 0, xclk_dead = 0, stop_mode = 0, osc_in_stop = 0;
  logic       gen_en, gen_stable;
  logic [6:0] mult_eff;

  int total = 0, failed = 0;
  bit finished = 0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;
  always #4 xclk = ~xclk;

  xclk_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .xclk(xclk), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_en(mon_en), .sel_ext(sel_ext),
    .xclk_dead(xclk_dead), .stop_mode(stop_mode), .osc_in_stop(osc_in_stop),
    .gen_en(gen_en), .gen_stable(gen_stable), .mult_eff(mult_eff)
  );

  // kind: 0 read data, 1 mult_eff, 2 gen_en, 3 gen_stable
  always begin
    @(negedge clk);
    if (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = {1'b0, mult_eff};
        2: act = {7'b0, gen_en};
        default: act = {7'b0, gen_stable};
      endcase
      total++;
      if (act !== it.exp) begin
        failed++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int kind, input logic a, input logic [7:0] e, input string req);
    item_t it;
    reg_addr = a;
    it.kind = kind; it.exp = e; it.req = req;
    sb.push_back(it);
    wait (sb.size() == 0);
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wr = 1; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    expect_val(0, 0, 8'h00, "R1");
    expect_val(0, 1, 8'h15, "R1");
    expect_val(3, 0, 8'h00, "R1");
    // R7 multiplier write, bit 7 reads 0
    wr(1, 8'hA3);
    expect_val(0, 1, 8'h23, "R7");
    expect_val(1, 1, 8'h23, "R8");
    // R8 zero maps to one
    wr(1, 8'h00);
    expect_val(0, 1, 8'h00, "R8");
    expect_val(1, 1, 8'h01, "R8");
    // R9 locked while monitor active
    mon_en = 1;
    wr(1, 8'h44);
    expect_val(0, 1, 8'h00, "R9");
    expect_val(2, 0, 8'h01, "R2");
    wr(0, 8'h00);
    expect_val(2, 0, 8'h01, "R2");
    mon_en = 0;
    repeat (2) @(posedge clk); #1;
    wr(1, 8'h7F);
    expect_val(1, 1, 8'h7F, "R9");
    // R3: clear in same cycle select drops is ignored
    @(posedge clk); #1 sel_ext = 1;
    repeat (3) @(posedge clk); #1;
    expect_val(2, 0, 8'h01, "R2");
    sel_ext = 0; reg_addr = 0; reg_wr = 1; reg_wdata = 8'h00;
    @(posedge clk); #1 reg_wr = 0;
    expect_val(2, 0, 8'h01, "R3");
    wr(0, 8'h00);
    expect_val(2, 0, 8'h00, "R3");
    // R10 bit 6 not writable, low bits zero
    wr(0, 8'h7F);
    expect_val(0, 0, 8'h00, "R10");
    // R4 set, R5 startup count
    wr(0, 8'h80);
    expect_val(0, 0, 8'h80, "R4");
    #32000;
    expect_val(3, 0, 8'h00, "R5");
    #2500;
    expect_val(3, 0, 8'h01, "R5");
    expect_val(0, 0, 8'hC0, "R10");
    // R6 stop with oscillator kept: no effect
    stop_mode = 1; osc_in_stop = 1;
    expect_val(3, 0, 8'h01, "R6");
    stop_mode = 0;
    xclk_dead = 1; #1;
    expect_val(3, 0, 8'h00, "R6");
    xclk_dead = 0;
    #20000;
    expect_val(3, 0, 8'h00, "R6");
    #15000;
    expect_val(3, 0, 8'h01, "R5");
    stop_mode = 1; osc_in_stop = 0; #1;
    expect_val(3, 0, 8'h00, "R6");
    stop_mode = 0;
    #35000;
    expect_val(3, 0, 8'h01, "R5");
    wr(0, 8'h00);
    expect_val(2, 0, 8'h00, "R3");
    expect_val(3, 0, 8'h00, "R6");
    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule